// File: doc/BRIEF.md
# Virtual Address Translator with Superpage Windows

This block turns a 64-bit virtual address into a physical address for a system with 8 KB pages. It holds a small, fully associative set of translation entries and also recognises two fixed address windows that map straight through, so an access falling into one of them never consults the entry set. A lookup is presented for one cycle with an access mask. One cycle later the block returns exactly one of three outcomes: a physical address, a miss, or an access violation.

Each entry keeps the virtual page tag, a protection word and the page frame already shifted into place. When an entry is stored, the three fault bits (fault on read, fault on write, fault on execute) are inverted. As a result, every permission the mask asks for is granted by a stored one, and the check reduces to a single AND across the selected bits. Entries are loaded through a one-cycle fill port that uses round-robin replacement, and a single invalidate pulse clears the whole set. Walking the page tables and handling faults are the job of the surrounding logic.

Top module: `va_xlate`

## Requirements
- R1: After reset `rsp_vld_o` is low and every entry is invalid, so the first lookup reports a miss.
- R2: A request on `req_vld_i` produces `rsp_vld_o` on the next cycle, and exactly one of `hit_o`, `miss_o`, `acv_o` is set with it.
- R3: An entry hits when it is valid and its tag equals virtual address bits 42:13. The physical address is then the stored frame number shifted left by 13, ORed with virtual address bits 12:0.
- R4: Protection input bit 1 (read fault), bit 2 (write fault) and bit 3 (execute fault) are active high at the fill port and are stored inverted. The other bits 15:0 are stored unchanged. Bits 31:16 of the 32-bit protection word always read as zero, so any mask bit in 31:16 denies the access.
- R5: A TLB hit is allowed only when every stored protection bit selected by `req_acc_i` is one. Otherwise the result is `acv_o`. An empty mask is always allowed.
- R6: When `sp43_en_i` is set, addresses 0xFFFFFC0000000000 to 0xFFFFFDFFFFFFFFFF hit with physical address equal to virtual bits 42:0. No permission check is made.
- R7: When `sp32_en_i` is set, addresses 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF hit with physical address equal to virtual bits 29:0. No permission check is made.
- R8: A superpage hit takes priority over a matching entry. A window whose enable is low is treated as an ordinary address.
- R9: A lookup that hits neither a window nor a valid entry reports `miss_o`. Every miss or violation returns `pa_o` equal to zero.
- R10: Fills go to entries 0, 1, ... in turn, wrapping after the last entry. The ninth fill after reset therefore replaces entry 0.
- R11: A pulse on `inv_all_i` clears every entry in one cycle. A fill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Lookup request |
| req_va_i | input | 64 | Virtual address to translate |
| req_acc_i | input | 32 | Protection bits the access requires |
| sp43_en_i | input | 1 | Enable for the 43-bit superpage window |
| sp32_en_i | input | 1 | Enable for the 32-bit superpage window |
| fill_i | input | 1 | Write one entry at the replacement pointer |
| fill_vpn_i | input | 30 | Tag (virtual bits 42:13) of the new entry |
| fill_prot_i | input | 16 | Protection bits, fault bits active high |
| fill_pfn_i | input | 31 | Page frame number of the new entry |
| inv_all_i | input | 1 | Invalidate all entries |
| rsp_vld_o | output | 1 | Result valid, one cycle after the request |
| pa_o | output | 44 | Physical address, zero on a fault |
| hit_o | output | 1 | Translation succeeded |
| miss_o | output | 1 | No window and no valid entry matched |
| acv_o | output | 1 | Entry matched but permission denied |

## Verification
The assertions check the following on every cycle: request-to-response timing, that exactly one outcome is set, that a fault carries a zero address, that the page offset passes through on a hit, that an enabled window wins, that each fill validates the entry the pointer named, and that invalidation empties the set. Only the bench scenarios can show the correct frame being picked, the inverted fault bits, the way the upper mask bits are denied, the exact window edges, and the eviction order.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W      = 64;
  localparam int PG_BITS   = 13;
  localparam int TAG_MSB   = 42;
  localparam int TAG_W     = TAG_MSB - PG_BITS + 1;
  localparam int PROT_W    = 32;
  localparam int PROT_USED = 16;
  localparam int PA_W      = 44;
  localparam int PFN_W     = PA_W - PG_BITS;

  // fault bits held inverted in the entry
  localparam int RD_FLT_BIT = 1;
  localparam int WR_FLT_BIT = 2;
  localparam int EX_FLT_BIT = 3;
  localparam logic [PROT_USED-1:0] FLT_INV_MASK =
    PROT_USED'((1 << RD_FLT_BIT) | (1 << WR_FLT_BIT) | (1 << EX_FLT_BIT));

  // superpage windows: bits above LSB must be ones, bit LSB zero
  localparam int SP43_LSB = 41;
  localparam int SP43_MAP = 43;
  localparam int SP32_LSB = 30;
  localparam int SP32_MAP = 30;

  typedef struct packed {
    logic                 vld;
    logic [TAG_W-1:0]     tag;
    logic [PROT_USED-1:0] prot;
    logic [PA_W-1:0]      frame;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    RES_HIT  = 2'd0,
    RES_MISS = 2'd1,
    RES_ACV  = 2'd2
  } res_e;
endpackage

// File: rtl/spage_win.sv
module spage_win
  import xlate_pkg::*;
#(
  parameter int MATCH_LSB = SP43_LSB,
  parameter int MAP_BITS  = SP43_MAP
) (
  input  logic [VA_W-1:0] va_i,
  input  logic            en_i,
  output logic            hit_o,
  output logic [PA_W-1:0] pa_o
);
  localparam int HI_W = VA_W - MATCH_LSB;
  localparam logic [HI_W-1:0] PATTERN = {{(HI_W-1){1'b1}}, 1'b0};

  assign hit_o = en_i && (va_i[VA_W-1:MATCH_LSB] == PATTERN);
  assign pa_o  = {{(PA_W-MAP_BITS){1'b0}}, va_i[MAP_BITS-1:0]};
endmodule

// File: rtl/perm_check.sv
module perm_check
  import xlate_pkg::*;
(
  input  logic [PROT_USED-1:0] prot_i,
  input  logic [PROT_W-1:0]    acc_i,
  output logic                 ok_o
);
  logic [PROT_W-1:0] prot_full;

  // upper half of the protection word reads as zero
  assign prot_full = {{(PROT_W-PROT_USED){1'b0}}, prot_i};
  assign ok_o      = ((acc_i & ~prot_full) == '0);
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import xlate_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fill_i,
  input  logic                 inv_i,
  input  logic [TAG_W-1:0]     fill_tag_i,
  input  logic [PROT_USED-1:0] fill_prot_i,
  input  logic [PFN_W-1:0]     fill_pfn_i,
  input  logic [TAG_W-1:0]     look_tag_i,
  output logic                 hit_o,
  output logic [PROT_USED-1:0] prot_o,
  output logic [PA_W-1:0]      frame_o
);
  localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_ENT - 1);

  tlb_ent_t             ent_q [N_ENT];
  logic [N_ENT-1:0]     vld_vec;
  logic [N_ENT-1:0]     match_vec;
  logic [PTR_W-1:0]     ptr_q;
  tlb_ent_t             new_ent;

  always_comb begin
    new_ent.vld   = 1'b1;
    new_ent.tag   = fill_tag_i;
    new_ent.prot  = fill_prot_i ^ FLT_INV_MASK;
    new_ent.frame = {fill_pfn_i, {PG_BITS{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
    end else if (inv_i) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i].vld <= 1'b0;
    end else if (fill_i) begin
      for (int i = 0; i < N_ENT; i++)
        if (ptr_q == PTR_W'(i)) ent_q[i] <= new_ent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= '0;
    else if (fill_i && !inv_i)  ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
    assign vld_vec[gi]   = ent_q[gi].vld;
    assign match_vec[gi] = ent_q[gi].vld && (ent_q[gi].tag == look_tag_i);
  end

  // lowest matching index wins
  always_comb begin
    hit_o   = 1'b0;
    prot_o  = '0;
    frame_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit_o   = 1'b1;
        prot_o  = ent_q[i].prot;
        frame_o = ent_q[i].frame;
      end
    end
  end

  AST_INV_CLEARS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> (vld_vec == '0)); // R11
  AST_FILL_VALIDATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inv_i) |=> vld_vec[$past(ptr_q)]); // R10
endmodule

// File: rtl/va_xlate.sv
module va_xlate
  import xlate_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_vld_i,
  input  logic [VA_W-1:0]      req_va_i,
  input  logic [PROT_W-1:0]    req_acc_i,
  input  logic                 sp43_en_i,
  input  logic                 sp32_en_i,
  input  logic                 fill_i,
  input  logic [TAG_W-1:0]     fill_vpn_i,
  input  logic [PROT_USED-1:0] fill_prot_i,
  input  logic [PFN_W-1:0]     fill_pfn_i,
  input  logic                 inv_all_i,
  output logic                 rsp_vld_o,
  output logic [PA_W-1:0]      pa_o,
  output logic                 hit_o,
  output logic                 miss_o,
  output logic                 acv_o
);
  logic [TAG_W-1:0]     look_tag;
  logic [PG_BITS-1:0]   pg_off;
  logic                 sp43_hit, sp32_hit, sp_hit;
  logic [PA_W-1:0]      sp43_pa, sp32_pa;
  logic                 tlb_hit, perm_ok;
  logic [PROT_USED-1:0] tlb_prot;
  logic [PA_W-1:0]      tlb_frame;
  res_e                 res_d;
  logic [PA_W-1:0]      pa_d;
  res_e                 res_q;
  logic                 rsp_q;
  logic [PA_W-1:0]      pa_q;

  assign look_tag = req_va_i[TAG_MSB:PG_BITS];
  assign pg_off   = req_va_i[PG_BITS-1:0];

  spage_win #(.MATCH_LSB(SP43_LSB), .MAP_BITS(SP43_MAP)) u_sp43 (
    .va_i(req_va_i), .en_i(sp43_en_i), .hit_o(sp43_hit), .pa_o(sp43_pa)
  );

  spage_win #(.MATCH_LSB(SP32_LSB), .MAP_BITS(SP32_MAP)) u_sp32 (
    .va_i(req_va_i), .en_i(sp32_en_i), .hit_o(sp32_hit), .pa_o(sp32_pa)
  );

  assign sp_hit = sp43_hit || sp32_hit;

  tlb_store #(.N_ENT(N_ENT)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (fill_i),
    .inv_i       (inv_all_i),
    .fill_tag_i  (fill_vpn_i),
    .fill_prot_i (fill_prot_i),
    .fill_pfn_i  (fill_pfn_i),
    .look_tag_i  (look_tag),
    .hit_o       (tlb_hit),
    .prot_o      (tlb_prot),
    .frame_o     (tlb_frame)
  );

  perm_check u_perm (
    .prot_i (tlb_prot),
    .acc_i  (req_acc_i),
    .ok_o   (perm_ok)
  );

  always_comb begin
    res_d = RES_MISS;
    pa_d  = '0;
    if (sp43_hit) begin
      res_d = RES_HIT;
      pa_d  = sp43_pa;
    end else if (sp32_hit) begin
      res_d = RES_HIT;
      pa_d  = sp32_pa;
    end else if (tlb_hit && perm_ok) begin
      res_d = RES_HIT;
      pa_d  = tlb_frame | {{(PA_W-PG_BITS){1'b0}}, pg_off};
    end else if (tlb_hit) begin
      res_d = RES_ACV;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= 1'b0;
      res_q <= RES_MISS;
      pa_q  <= '0;
    end else begin
      rsp_q <= req_vld_i;
      if (req_vld_i) begin
        res_q <= res_d;
        pa_q  <= pa_d;
      end
    end
  end

  assign rsp_vld_o = rsp_q;
  assign pa_o      = rsp_q ? pa_q : '0;
  assign hit_o     = rsp_q && (res_q == RES_HIT);
  assign miss_o    = rsp_q && (res_q == RES_MISS);
  assign acv_o     = rsp_q && (res_q == RES_ACV);

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> rsp_vld_o); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |-> ($countones({hit_o, miss_o, acv_o}) == 1)); // R2
  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && !hit_o) |-> (pa_o == '0)); // R9
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> (!hit_o || (pa_o[PG_BITS-1:0] == $past(req_va_i[PG_BITS-1:0])))); // R3
  AST_SP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && sp_hit) |=> hit_o); // R8
endmodule

// File: tb/sim_va_xlate.sv
module sim_va_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct {
    int          kind;  // 0 hit, 1 miss, 2 acv
    logic [43:0] pa;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [63:0] req_va = '0;
  logic [31:0] req_acc = '0;
  logic        sp43_en = 1'b0;
  logic        sp32_en = 1'b0;
  logic        fill = 1'b0;
  logic [29:0] fill_vpn = '0;
  logic [15:0] fill_prot = '0;
  logic [30:0] fill_pfn = '0;
  logic        inv_all = 1'b0;
  logic        rsp_vld;
  logic [43:0] pa;
  logic        hit, miss, acv;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  va_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_vld_i(req_vld), .req_va_i(req_va),
    .req_acc_i(req_acc), .sp43_en_i(sp43_en), .sp32_en_i(sp32_en),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_prot_i(fill_prot),
    .fill_pfn_i(fill_pfn), .inv_all_i(inv_all), .rsp_vld_o(rsp_vld),
    .pa_o(pa), .hit_o(hit), .miss_o(miss), .acv_o(acv)
  );

  function automatic logic [63:0] va_of(input logic [29:0] tag, input logic [12:0] off);
    return {21'h0, tag, off};
  endfunction

  function automatic logic [43:0] pa_of(input logic [30:0] pfn, input logic [12:0] off);
    return {pfn, off};
  endfunction

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic do_fill(input logic [29:0] tag, input logic [30:0] pfn,
                         input logic [15:0] prot, input logic inv);
    @(negedge clk);
    fill = 1'b1; fill_vpn = tag; fill_pfn = pfn; fill_prot = prot; inv_all = inv;
    @(negedge clk);
    fill = 1'b0; inv_all = 1'b0;
  endtask

  task automatic do_inv;
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  task automatic look(input logic [63:0] va, input logic [31:0] acc,
                      input logic e43, input logic e32,
                      input int kind, input logic [43:0] xpa, input string r);
    exp_t e;
    @(negedge clk);
    req_vld = 1'b1; req_va = va; req_acc = acc; sp43_en = e43; sp32_en = e32;
    e.kind = kind; e.pa = (kind == 0) ? xpa : 44'h0; e.req = r;
    exp_q.push_back(e);
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && rsp_vld) begin
      int   act;
      exp_t e;
      act = hit ? 0 : (miss ? 1 : (acv ? 2 : 3));
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected response kind=%0d pa=%h expected none", act, pa);
      end else begin
        e = exp_q.pop_front();
        if (act != e.kind || pa !== e.pa || (hit + miss + acv) != 1) begin
          failures++;
          $display("FAIL %s kind=%0d pa=%h expected kind=%0d pa=%h", e.req, act, pa, e.kind, e.pa);
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [63:0] va_p;
    logic [29:0] tag_p;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_vld !== 1'b0) begin
      failures++;
      $display("FAIL R1 rsp_vld=%b expected 0", rsp_vld);
    end
    look(va_of(30'h5, 13'h10), 32'h2, 1'b0, 1'b0, 1, 44'h0, "R1 first lookup misses");
    look(va_of(30'h105, 13'h0), 32'h0, 1'b0, 1'b0, 1, 44'h0, "R9 empty set miss");

    // fill all eight entries
    for (int k = 0; k < 8; k++)
      do_fill(30'h100 + 30'(k), 31'h40 + 31'(k), 16'h00F0, 1'b0);
    look(va_of(30'h100, 13'h1ABC), 32'h2, 1'b0, 1'b0, 0, pa_of(31'h40, 13'h1ABC), "R3 entry0 hit");
    look(va_of(30'h103, 13'h0007), 32'h2, 1'b0, 1'b0, 0, pa_of(31'h43, 13'h0007), "R3 entry3 hit");
    look(va_of(30'h107, 13'h1FFF), 32'hE, 1'b0, 1'b0, 0, pa_of(31'h47, 13'h1FFF), "R5 all faults clear");
    look(va_of(30'h108, 13'h0), 32'h2, 1'b0, 1'b0, 1, 44'h0, "R9 unknown tag");

    // ninth fill: write fault set, bit4 set, replaces entry 0
    do_fill(30'h200, 31'h77, 16'h0014, 1'b0);
    look(va_of(30'h100, 13'h0), 32'h2, 1'b0, 1'b0, 1, 44'h0, "R10 entry0 evicted");
    look(va_of(30'h101, 13'h0020), 32'h2, 1'b0, 1'b0, 0, pa_of(31'h41, 13'h0020), "R10 entry1 kept");
    look(va_of(30'h200, 13'h0123), 32'h2, 1'b0, 1'b0, 0, pa_of(31'h77, 13'h0123), "R4 read allowed");
    look(va_of(30'h200, 13'h0123), 32'h8, 1'b0, 1'b0, 0, pa_of(31'h77, 13'h0123), "R4 exec allowed");
    look(va_of(30'h200, 13'h0123), 32'h4, 1'b0, 1'b0, 2, 44'h0, "R4 write fault");
    look(va_of(30'h200, 13'h0004), 32'h10, 1'b0, 1'b0, 0, pa_of(31'h77, 13'h0004), "R5 plain bit set");
    look(va_of(30'h200, 13'h0004), 32'h20, 1'b0, 1'b0, 2, 44'h0, "R5 plain bit clear");
    look(va_of(30'h200, 13'h0004), 32'h1A, 1'b0, 1'b0, 0, pa_of(31'h77, 13'h0004), "R5 multi bit ok");
    look(va_of(30'h200, 13'h0004), 32'h1E, 1'b0, 1'b0, 2, 44'h0, "R5 multi bit deny");
    look(va_of(30'h200, 13'h0004), 32'h0, 1'b0, 1'b0, 0, pa_of(31'h77, 13'h0004), "R5 empty mask");
    look(va_of(30'h200, 13'h0004), 32'h0001_0000, 1'b0, 1'b0, 2, 44'h0, "R4 upper half zero");
    look(va_of(30'h101, 13'h0004), 32'h8000_0002, 1'b0, 1'b0, 2, 44'h0, "R4 bit31 denies");

    // superpage windows
    look(64'hFFFF_FC00_0000_1234, 32'hFFFF_FFFF, 1'b1, 1'b0, 0, 44'h400_0000_1234, "R6 low edge no perm");
    look(64'hFFFF_FDFF_FFFF_FFFF, 32'h2, 1'b1, 1'b0, 0, 44'h5FF_FFFF_FFFF, "R6 high edge");
    look(64'hFFFF_FE00_0000_0000, 32'h2, 1'b1, 1'b0, 1, 44'h0, "R6 above window");
    look(64'hFFFF_FBFF_FFFF_FFFF, 32'h2, 1'b1, 1'b0, 1, 44'h0, "R6 below window");
    look(64'hFFFF_FC00_0000_1234, 32'h2, 1'b0, 1'b0, 1, 44'h0, "R8 43b window disabled");
    look(64'hFFFF_FFFF_8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 0, 44'h0, "R7 low edge");
    look(64'hFFFF_FFFF_BFFF_FFFF, 32'h2, 1'b0, 1'b1, 0, 44'h0_3FFF_FFFF, "R7 high edge");
    look(64'hFFFF_FFFF_C000_0000, 32'h2, 1'b0, 1'b1, 1, 44'h0, "R7 above window");
    look(64'hFFFF_FFFF_7FFF_FFFF, 32'h2, 1'b0, 1'b1, 1, 44'h0, "R7 below window");

    // priority: entry matching a 32b window address
    va_p  = 64'hFFFF_FFFF_8000_2468;
    tag_p = va_p[42:13];
    do_fill(tag_p, 31'h55, 16'h00F0, 1'b0);
    look(va_p, 32'h2, 1'b0, 1'b1, 0, {14'h0, va_p[29:0]}, "R8 window beats entry");
    look(va_p, 32'h2, 1'b0, 1'b0, 0, pa_of(31'h55, va_p[12:0]), "R8 disabled falls to entry");

    // invalidate
    do_inv();
    look(va_of(30'h102, 13'h0), 32'h2, 1'b0, 1'b0, 1, 44'h0, "R11 invalidated entry");
    look(va_of(30'h200, 13'h0), 32'h0, 1'b0, 1'b0, 1, 44'h0, "R11 invalidated entry2");
    do_fill(30'h300, 31'h12, 16'h00F0, 1'b1);
    look(va_of(30'h300, 13'h0), 32'h2, 1'b0, 1'b0, 1, 44'h0, "R11 fill with invalidate dropped");
    do_fill(30'h301, 31'h13, 16'h00F0, 1'b0);
    look(va_of(30'h301, 13'h0ABC), 32'h2, 1'b0, 1'b0, 0, pa_of(31'h13, 13'h0ABC), "R3 fill after invalidate");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 %0d responses missing expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      report();
      $finish;
    end
  end
endmodule